// File: doc/BRIEF.md
# Dual-Enable Asynchronous Static Memory

This block is a synthesizable behavioural model of a static word memory, 8192 words of 8 bits by default, with a control interface that has no strobe of its own. Four level-sensitive controls set the operating mode. The controls are an active-low select, an active-high enable, an active-low output enable and an active-low write enable. The decoded modes are read, write, output-off and standby. The bidirectional data bus of a real part appears here as three ports: an input word, an output word and an output-driver enable.

Reads are combinational from the address and controls, so the addressed word and the driver enable follow the pins with no clock. A write is the window in which the part is selected, enabled and has write enable low. The model samples that window on the system clock. It stores the address and data seen at the last clock edge inside the window. The store happens when the window closes, whichever control closes it. A read of the same address in the same half-cycle that the window closes already returns the new word.

Top module: `dual_enable_sram`

## Requirements
- R1: The memory holds 2**ADDR_W independent words of DATA_W bits (8192 x 8 by default); every address, including 0 and the highest, returns the word last stored there.
- R2: With csN=0, ce=1, weN=1 and oeN=0 (read), doutEn is 1 and dout shows the addressed word combinationally, without waiting for a clock edge.
- R3: While csN=0, ce=1 and weN=0 (write), din is stored at addr whatever the level of oeN.
- R4: A write is stored when its window closes, by weN rising, csN rising or ce falling, whichever comes first; the address and data stored are those present at the last rising clock edge inside the window.
- R5: With csN=0, ce=1, weN=1 and oeN=1 (output-off), doutEn is 0 and nothing is written.
- R6: csN=1 forces standby: doutEn is 0 and a low weN writes nothing.
- R7: ce=0 forces standby: doutEn is 0 and a low weN writes nothing.
- R8: weN=0 keeps doutEn at 0 even when oeN=0.
- R9: Whenever doutEn is 0, dout is all zeros.
- R10: Once a write window has closed, a read of the same address returns the new word immediately, before the next clock edge.
- R11: rstN=0 resets the write tracking, so a write window that closes while rstN is low stores nothing; the stored words themselves are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the write window |
| rstN | input | 1 | Active-low asynchronous reset of write tracking |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data from the bus |
| csN | input | 1 | Active-low select |
| ce | input | 1 | Active-high enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| dout | output | DATA_W | Read data, zero when not driven |
| doutEn | output | 1 | Data driver enable (bus not high-impedance) |

## Verification
A wrong mode decode shows at once as doutEn on or off against the truth table, in the same half-cycle as the control change. A wrong captured address or data word, or a dropped or extra store, stays hidden in the array until that address is read back. For that reason every word is loaded, read back across the full array, and then overwritten and read back under each control combination. A missing bypass shows only in the half-cycle between the window closing and the next clock edge, so the bench samples inside that gap.

// File: rtl/dual_enable_sram_pkg.sv
package dual_enable_sram_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_READ    = 2'd1,
    MODE_WRITE   = 2'd2,
    MODE_OUTOFF  = 2'd3
  } memMode_e;

  typedef struct packed {
    logic capture;   // write window open: sample addr and din
    logic commit;    // write window just closed: store sample
    logic drive;     // read mode: enable the data driver
  } memStrobes_t;

endpackage

// File: rtl/dual_enable_sram_ctrl.sv
module dual_enable_sram_ctrl
  import dual_enable_sram_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        ce,
  input  logic        oeN,
  input  logic        weN,
  output memStrobes_t strobes
);

  memMode_e mode;
  logic     writeNow;
  logic     wrActive;

  always_comb begin
    if (csN || !ce)   mode = MODE_STANDBY;
    else if (!weN)    mode = MODE_WRITE;
    else if (!oeN)    mode = MODE_READ;
    else              mode = MODE_OUTOFF;
  end

  assign writeNow = (mode == MODE_WRITE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrActive <= 1'b0;
    else       wrActive <= writeNow;
  end

  always_comb begin
    strobes.capture = writeNow;
    strobes.commit  = wrActive && !writeNow;
    strobes.drive   = (mode == MODE_READ);
  end

  // R4
  window_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!csN && ce && !weN) && (csN || !ce || weN)) |-> strobes.commit);

  // R3
  commit_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> $past(!csN && ce && !weN));

endmodule

// File: rtl/dual_enable_sram_datapath.sv
module dual_enable_sram_datapath
  import dual_enable_sram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] readData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capData;
  logic              capValid;
  logic [DATA_W-1:0] rawData;

  always_ff @(posedge clk) begin
    if (strobes.capture) begin
      capAddr <= addr;
      capData <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.commit) mem[capAddr] <= capData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                capValid <= 1'b0;
    else if (strobes.capture) capValid <= 1'b1;
    else if (strobes.commit)  capValid <= 1'b0;
  end

  // pending store is forwarded so a read right after the window sees it
  always_comb begin
    if (strobes.commit && (addr == capAddr)) rawData = capData;
    else                                     rawData = mem[addr];
    readData = strobes.drive ? rawData : '0;
  end

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.drive |-> (readData == '0));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.capture, strobes.commit}));

  // R11
  commit_has_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> capValid);

  // R1
  store_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> (mem[$past(capAddr)] == $past(capData)));

endmodule

// File: rtl/dual_enable_sram.sv
module dual_enable_sram
  import dual_enable_sram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              csN,
  input  logic              ce,
  input  logic              oeN,
  input  logic              weN,
  output logic [DATA_W-1:0] dout,
  output logic              doutEn
);

  memStrobes_t strobes;

  dual_enable_sram_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .ce      (ce),
    .oeN     (oeN),
    .weN     (weN),
    .strobes (strobes)
  );

  dual_enable_sram_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .addr     (addr),
    .din      (din),
    .readData (dout)
  );

  assign doutEn = strobes.drive;

  // R8
  we_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    doutEn |-> weN);

  // R6
  cs_standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !doutEn);

  // R7
  ce_standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ce |-> !doutEn);

endmodule

// File: tb/dual_enable_sram_bench.sv
module dual_enable_sram_bench;

  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic [3:0] ctl;    // {csN, ce, oeN, weN}
    logic       expEn;
    logic       expWr;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{4'b0000, 1'b0, 1'b0}, '{4'b0001, 1'b0, 1'b0},
    '{4'b0010, 1'b0, 1'b0}, '{4'b0011, 1'b0, 1'b0},
    '{4'b0100, 1'b0, 1'b1}, '{4'b0101, 1'b1, 1'b0},
    '{4'b0110, 1'b0, 1'b1}, '{4'b0111, 1'b0, 1'b0},
    '{4'b1000, 1'b0, 1'b0}, '{4'b1001, 1'b0, 1'b0},
    '{4'b1010, 1'b0, 1'b0}, '{4'b1011, 1'b0, 1'b0},
    '{4'b1100, 1'b0, 1'b0}, '{4'b1101, 1'b0, 1'b0},
    '{4'b1110, 1'b0, 1'b0}, '{4'b1111, 1'b0, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic              csN = 1'b1;
  logic              ce = 1'b1;
  logic              oeN = 1'b1;
  logic              weN = 1'b1;
  logic [DATA_W-1:0] dout;
  logic              doutEn;

  logic [DATA_W-1:0] model [DEPTH];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_enable_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dual_enable_sram (
    .clk(clk), .rstN(rstN), .addr(addr), .din(din), .csN(csN), .ce(ce),
    .oeN(oeN), .weN(weN), .dout(dout), .doutEn(doutEn)
  );

  function automatic logic [DATA_W-1:0] pat(input int a);
    logic [12:0] w;
    w = 13'(a);
    return w[7:0] ^ {w[12:8], 3'b011};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setIdle();
    csN = 1'b1; ce = 1'b1; oeN = 1'b1; weN = 1'b1;
  endtask

  task automatic doWrite(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); din = d; csN = 1'b0; ce = 1'b1; oeN = 1'b1; weN = 1'b0;
    @(negedge clk);
    setIdle();
    model[a] = d;
  endtask

  task automatic readCheck(input int a, input string req);
    @(negedge clk);
    addr = ADDR_W'(a); csN = 1'b0; ce = 1'b1; oeN = 1'b0; weN = 1'b1;
    #1;
    check(doutEn === 1'b1 && dout === model[a], req, {doutEn, dout}, {1'b1, model[a]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    // reset state, R9
    repeat (2) @(negedge clk);
    check(doutEn === 1'b0 && dout === '0, "R9 reset", {doutEn, dout}, 0);
    rstN = 1'b1;

    // R1: load and read back the whole array
    for (int a = 0; a < DEPTH; a++) doWrite(a, pat(a));
    begin
      int errs = 0;
      for (int a = 0; a < DEPTH; a++) begin
        @(negedge clk);
        addr = ADDR_W'(a); csN = 1'b0; ce = 1'b1; oeN = 1'b0; weN = 1'b1;
        #1;
        if (dout !== model[a] || doutEn !== 1'b1) errs++;
      end
      check(errs == 0, "R1 full readback", errs, 0);
    end
    readCheck(0, "R1 lowest");
    readCheck(DEPTH - 1, "R1 highest");

    // control table: R2 R3 R5 R6 R7 R8 R9
    for (int i = 0; i < 16; i++) begin
      int a;
      string req;
      a = (i * 517 + 3) % DEPTH;
      if (VECS[i].ctl[3])      req = "R6";
      else if (!VECS[i].ctl[2]) req = "R7";
      else if (!VECS[i].ctl[0]) req = "R8";
      else if (!VECS[i].ctl[1]) req = "R2";
      else                      req = "R5";
      @(negedge clk);
      addr = ADDR_W'(a); din = ~model[a];
      {csN, ce, oeN, weN} = VECS[i].ctl;
      #1;
      check(doutEn === VECS[i].expEn, req, doutEn, VECS[i].expEn);
      check(dout === (VECS[i].expEn ? model[a] : '0), "R9", dout,
            VECS[i].expEn ? model[a] : 0);
      @(negedge clk);
      setIdle();
      if (VECS[i].expWr) model[a] = ~model[a];
      readCheck(a, VECS[i].expWr ? "R3 stored" : "R5 R6 R7 nothing stored");
    end

    // R4: window closed by ce falling
    @(negedge clk);
    addr = 13'd100; din = ~model[100]; csN = 1'b0; ce = 1'b1; oeN = 1'b1; weN = 1'b0;
    @(negedge clk);
    ce = 1'b0;
    model[100] = din;
    @(negedge clk);
    setIdle();
    readCheck(100, "R4 ce close");

    // R4: window closed by csN rising
    @(negedge clk);
    addr = 13'd101; din = ~model[101]; csN = 1'b0; ce = 1'b1; oeN = 1'b0; weN = 1'b0;
    @(negedge clk);
    csN = 1'b1;
    model[101] = din;
    @(negedge clk);
    setIdle();
    readCheck(101, "R4 cs close");

    // R4: data at last edge in window wins
    @(negedge clk);
    addr = 13'd102; din = 8'h11; csN = 1'b0; ce = 1'b1; oeN = 1'b1; weN = 1'b0;
    @(negedge clk);
    din = 8'h22;
    @(negedge clk);
    weN = 1'b1;
    din = 8'h33;
    model[102] = 8'h22;
    @(negedge clk);
    setIdle();
    readCheck(102, "R4 last sample");

    // R10: read in the gap before the store edge
    @(negedge clk);
    addr = 13'd200; din = ~model[200]; csN = 1'b0; ce = 1'b1; oeN = 1'b1; weN = 1'b0;
    model[200] = din;
    @(negedge clk);
    weN = 1'b1; oeN = 1'b0;
    #1;
    check(doutEn === 1'b1 && dout === model[200], "R10 bypass", dout, model[200]);
    @(negedge clk);
    setIdle();
    readCheck(200, "R10 after store");

    // R11: window closed during reset stores nothing
    @(negedge clk);
    addr = 13'd300; din = ~model[300]; csN = 1'b0; ce = 1'b1; oeN = 1'b1; weN = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    setIdle();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    readCheck(300, "R11 reset discard");

    done = 1'b1;
    @(negedge clk);
    setIdle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule